// File: doc/BRIEF.md
# DRAM Address Multiplexer and Strobe Sequencer

This block sits between a system bus and a DRAM array of four banks. It captures a system address made of a row half and a column half, together with two bank-select bits. The capture register passes values straight through while the address strobe is high and holds them once the strobe is low. The block drives the multiplexed address pins, four active-low row strobes, an active-low column strobe and an active-low write enable.

With `ext_ctrl` low, the block sequences accesses and refreshes by itself on the clock. An access asserts the row strobe of the selected bank, holds the row address for one or two cycles, switches to the column address, and then asserts the column strobe. A refresh request starts a RAS-only refresh of all four banks from an internal refresh counter.

With `ext_ctrl` high, the host drives the strobes directly. The column strobe can then be pulsed several times within one row strobe. Refreshes in this mode last as long as the host holds the refresh request.

Top module: `dram_amux_seq`

## Requirements
- R1: The row half (`sys_addr[AW-1:0]`), the column half (`sys_addr[2*AW-1:AW]`) and `bank_sel` pass through while `addr_strobe` is 1. When `addr_strobe` is 0 they hold the value sampled at the last rising clock edge where the strobe was 1. While idle, `dram_addr` shows the effective row half.
- R2: With `paired_banks`=0, an access drives exactly one row strobe low: `bank_sel` 0 selects `ras_n[0]`, 1 selects `ras_n[1]`, 2 selects `ras_n[2]` and 3 selects `ras_n[3]`.
- R3: With `paired_banks`=1, only `bank_sel[1]` is used. A 0 drives `ras_n[1:0]` low and a 1 drives `ras_n[3:2]` low.
- R4: In automatic mode, an `access_req` sampled high while idle makes the row strobe active from the next cycle with the row address on `dram_addr`. After the row hold, `dram_addr` carries the column half for one cycle with `cas_n` high. From the following cycle `cas_n` is low.
- R5: The row hold lasts 1 cycle when `long_row_hold`=0 and 2 cycles when it is 1.
- R6: `access_done` is high for exactly one cycle, namely the first cycle in which `cas_n` is low during an automatic access.
- R7: In automatic mode, if `access_req` is sampled low during an access, all strobes are inactive from the next cycle.
- R8: In external mode, while `access_req` is 1 the selected row strobe is low, `mux_col_in`=1 selects the column half, and `cas_n` equals `~cas_in`. This allows several CAS pulses inside one row strobe.
- R9: An automatic refresh drives all four `ras_n` low for REF_CYC cycles (default 3). During that time `dram_addr` equals the zero-extended refresh counter and `cas_n` stays high.
- R10: The refresh counter (RW bits, default 9) rises by one after each refresh and wraps from its maximum value to 0.
- R11: `we_n` equals `write_n` combinationally in every mode and state.
- R12: Reset clears the refresh counter and all control state. All strobes are inactive after reset, and the first refresh uses address 0.
- R13: A refresh requested during an automatic access is held pending and runs once the access ends. An access requested during a refresh starts only after the refresh. When both are waiting while idle, the refresh goes first.
- R14: In external mode, with `refresh_req`=1 and `access_req`=0, all row strobes are low and the counter value is on `dram_addr`. The counter advances when that condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_addr | input | 2*AW | System address; the low half is the row, the high half is the column |
| bank_sel | input | 2 | Bank select bits |
| addr_strobe | input | 1 | 1 = capture passes through, 0 = hold |
| paired_banks | input | 1 | 1 = pairwise row strobe decode |
| ext_ctrl | input | 1 | 1 = external control mode |
| access_req | input | 1 | Access request; in external mode it also acts as the row strobe |
| long_row_hold | input | 1 | Selects a 2-cycle row hold instead of 1 cycle |
| mux_col_in | input | 1 | External mode: selects the column address |
| cas_in | input | 1 | External mode: column strobe, active high |
| write_n | input | 1 | Write request, active low |
| refresh_req | input | 1 | Refresh request |
| dram_addr | output | AW | Multiplexed DRAM address |
| ras_n | output | 4 | Row strobes, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| access_done | output | 1 | One-cycle pulse when CAS is first asserted |

## Verification
The bench targets a refresh pulse that lands in the middle of an access. A design without a pending flag would lose that refresh, and a design that starts it at once would assert CAS while all four banks are being refreshed. It also targets a row-hold setting that changes between accesses, and a capture strobe that falls while the address keeps moving. A faulty capture would send the newer address to the DRAM. Finally, it runs more than 512 refreshes so that the counter wraps. A counter that saturates, or that does not clear on reset, shows up there as the wrong refresh address.

// File: rtl/dram_amux_pkg.sv
package dram_amux_pkg;

    localparam int NUM_BANKS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_REF
    } seq_state_t;

    typedef struct packed {
        logic ras_on;
        logic col_sel;
        logic cas_on;
        logic refresh;
    } strobe_ctl_t;

    function automatic logic [NUM_BANKS-1:0] bank_enables(input logic paired,
                                                          input logic [1:0] bsel);
        logic [NUM_BANKS-1:0] en;
        if (paired) begin
            en = bsel[1] ? 4'b1100 : 4'b0011;
        end else begin
            en = 4'b0001 << bsel;
        end
        return en;
    endfunction

endpackage

// File: rtl/dram_addr_capture.sv
module dram_addr_capture #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [2*AW-1:0] sys_addr,
    input  logic [1:0]    bank_in,
    output logic [AW-1:0] row_addr,
    output logic [AW-1:0] col_addr,
    output logic [1:0]    bank_eff
);
    localparam int HW = 2 * AW + 2;

    logic [HW-1:0] held_q;
    logic [HW-1:0] live;
    logic [HW-1:0] eff;

    assign live = {bank_in, sys_addr};

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (strobe) begin
            held_q <= live;
        end
    end

    assign eff      = strobe ? live : held_q;
    assign row_addr = eff[AW-1:0];
    assign col_addr = eff[2*AW-1:AW];
    assign bank_eff = eff[HW-1:2*AW];
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [RW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
    import dram_amux_pkg::*;
#(
    parameter int REF_CYC = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_ctrl,
    input  logic        access_req,
    input  logic        refresh_req,
    input  logic        long_hold,
    input  logic        mux_col_in,
    input  logic        cas_in,
    output strobe_ctl_t ctl,
    output logic        done,
    output logic        ref_inc
);
    localparam int CW = (REF_CYC > 2) ? $clog2(REF_CYC) : 1;
    localparam logic [CW-1:0] REF_LAST = CW'(REF_CYC - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] hold_last;
    logic          pend_q;
    logic          ext_ref_q;
    logic          done_q;
    logic          start_ref;
    logic          auto_inc;
    logic          idle;
    logic          ext_acc;
    logic          ext_ref;

    assign hold_last = long_hold ? CW'(1) : CW'(0);
    assign idle      = (state_q == ST_IDLE);
    assign ext_acc   = ext_ctrl && idle && access_req;
    assign ext_ref   = ext_ctrl && idle && refresh_req && !access_req;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        start_ref = 1'b0;
        auto_inc  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (!ext_ctrl) begin
                    if (pend_q || refresh_req) begin
                        state_d   = ST_REF;
                        cnt_d     = '0;
                        start_ref = 1'b1;
                    end else if (access_req) begin
                        state_d = ST_ROW;
                        cnt_d   = '0;
                    end
                end
            end
            ST_ROW: begin
                if (!access_req) begin
                    state_d = ST_IDLE;
                end else if (cnt_q >= hold_last) begin
                    state_d = ST_COL;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_COL: begin
                state_d = access_req ? ST_CAS : ST_IDLE;
            end
            ST_CAS: begin
                if (!access_req) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REF: begin
                if (cnt_q >= REF_LAST) begin
                    state_d  = ST_IDLE;
                    auto_inc = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            pend_q    <= 1'b0;
            ext_ref_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            pend_q    <= (pend_q | (refresh_req & ~ext_ctrl)) & ~start_ref;
            ext_ref_q <= ext_ref;
            done_q    <= (state_q == ST_COL) && access_req;
        end
    end

    always_comb begin
        ctl.ras_on  = (state_q == ST_ROW) || (state_q == ST_COL) ||
                      (state_q == ST_CAS) || ext_acc;
        ctl.col_sel = (state_q == ST_COL) || (state_q == ST_CAS) ||
                      (ext_acc && mux_col_in);
        ctl.cas_on  = (state_q == ST_CAS) || (ext_acc && cas_in);
        ctl.refresh = (state_q == ST_REF) || ext_ref;
    end

    assign done    = done_q;
    assign ref_inc = auto_inc | (ext_ref_q & ~ext_ref);
endmodule

// File: rtl/dram_amux_seq.sv
module dram_amux_seq
    import dram_amux_pkg::*;
#(
    parameter int AW      = 10,
    parameter int RW      = 9,
    parameter int REF_CYC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2*AW-1:0] sys_addr,
    input  logic [1:0]      bank_sel,
    input  logic            addr_strobe,
    input  logic            paired_banks,
    input  logic            ext_ctrl,
    input  logic            access_req,
    input  logic            long_row_hold,
    input  logic            mux_col_in,
    input  logic            cas_in,
    input  logic            write_n,
    input  logic            refresh_req,
    output logic [AW-1:0]   dram_addr,
    output logic [3:0]      ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic            access_done
);
    logic [AW-1:0]        row_addr;
    logic [AW-1:0]        col_addr;
    logic [1:0]           bank_eff;
    logic [RW-1:0]        ref_count;
    logic                 ref_inc;
    strobe_ctl_t          ctl;
    logic [NUM_BANKS-1:0] bank_en;

    dram_addr_capture #(.AW(AW)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .strobe   (addr_strobe),
        .sys_addr (sys_addr),
        .bank_in  (bank_sel),
        .row_addr (row_addr),
        .col_addr (col_addr),
        .bank_eff (bank_eff)
    );

    dram_refresh_ctr #(.RW(RW)) u_refctr (
        .clk   (clk),
        .rst   (rst),
        .inc   (ref_inc),
        .count (ref_count)
    );

    dram_access_seq #(.REF_CYC(REF_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ext_ctrl    (ext_ctrl),
        .access_req  (access_req),
        .refresh_req (refresh_req),
        .long_hold   (long_row_hold),
        .mux_col_in  (mux_col_in),
        .cas_in      (cas_in),
        .ctl         (ctl),
        .done        (access_done),
        .ref_inc     (ref_inc)
    );

    assign bank_en = bank_enables(paired_banks, bank_eff);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ras
            assign ras_n[b] = ~(ctl.refresh | (ctl.ras_on & bank_en[b]));
        end
    endgenerate

    always_comb begin
        if (ctl.refresh) begin
            dram_addr = AW'(ref_count);
        end else if (ctl.col_sel) begin
            dram_addr = col_addr;
        end else begin
            dram_addr = row_addr;
        end
    end

    assign cas_n = ~(ctl.cas_on & ~ctl.refresh);
    assign we_n  = write_n;
endmodule

// File: rtl/dram_amux_seq_chk.sv
module dram_amux_seq_chk #(
    parameter int RW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          paired_banks,
    input logic          ext_ctrl,
    input logic          access_req,
    input logic          write_n,
    input logic [3:0]    ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          access_done,
    input logic [RW-1:0] ref_count
);
    p_refresh_no_cas_r9: assert property (@(posedge clk) disable iff (rst)
        (ras_n == 4'h0) |-> cas_n);

    p_single_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (!paired_banks && ras_n != 4'hF && ras_n != 4'h0) |-> ($countones(~ras_n) == 1));

    p_pair_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (paired_banks && ras_n != 4'hF && ras_n != 4'h0) |->
        (ras_n == 4'b1100 || ras_n == 4'b0011));

    p_we_follow_r11: assert property (@(posedge clk) disable iff (rst)
        we_n == write_n);

    p_done_with_cas_r6: assert property (@(posedge clk) disable iff (rst)
        access_done |-> !cas_n);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        access_done |=> !access_done);

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (!ext_ctrl && !access_req && !cas_n) |=> (cas_n || ext_ctrl));

    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_count) |-> (ref_count == RW'($past(ref_count) + 1'b1)));
endmodule

bind dram_amux_seq dram_amux_seq_chk #(.RW(RW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .paired_banks (paired_banks),
    .ext_ctrl     (ext_ctrl),
    .access_req   (access_req),
    .write_n      (write_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .access_done  (access_done),
    .ref_count    (ref_count)
);

// File: tb/dram_amux_seq_bench.sv
module dram_amux_seq_bench;
    localparam int AW = 10;
    localparam int RW = 9;
    localparam int REF_CYC = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2*AW-1:0] sys_addr = '0;
    logic [1:0]      bank_sel = '0;
    logic            addr_strobe = 1'b1;
    logic            paired_banks = 1'b0;
    logic            ext_ctrl = 1'b0;
    logic            access_req = 1'b0;
    logic            long_row_hold = 1'b0;
    logic            mux_col_in = 1'b0;
    logic            cas_in = 1'b0;
    logic            write_n = 1'b1;
    logic            refresh_req = 1'b0;
    logic [AW-1:0]   dram_addr;
    logic [3:0]      ras_n;
    logic            cas_n;
    logic            we_n;
    logic            access_done;

    int checks = 0;
    int failures = 0;
    string cur_req = "R12";
    bit started = 0;
    bit finished = 0;

    // reference model state
    int m_phase = 0;   // 0 idle, 1 row, 2 col, 3 cas, 4 refresh
    int m_cnt = 0;
    int m_pend = 0;
    int m_refcnt = 0;
    int m_done = 0;
    int m_extq = 0;
    int m_held_addr = 0;
    int m_held_bank = 0;

    always #5 clk = ~clk;

    dram_amux_seq u_dram_amux_seq (
        .clk(clk), .rst(rst), .sys_addr(sys_addr), .bank_sel(bank_sel),
        .addr_strobe(addr_strobe), .paired_banks(paired_banks), .ext_ctrl(ext_ctrl),
        .access_req(access_req), .long_row_hold(long_row_hold), .mux_col_in(mux_col_in),
        .cas_in(cas_in), .write_n(write_n), .refresh_req(refresh_req),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .access_done(access_done)
    );

    task automatic check_eq(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    function automatic int ext_ref_now();
        return (ext_ctrl && m_phase == 0 && refresh_req && !access_req) ? 1 : 0;
    endfunction

    // per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        #2;
        if (started && !rst && !finished) begin
            int eff_addr, eff_bank, row, col, en, ras_act, colsel, cas_act, refr, exp_ras, exp_addr;
            eff_addr = addr_strobe ? int'(sys_addr) : m_held_addr;
            eff_bank = addr_strobe ? int'(bank_sel) : m_held_bank;
            row = eff_addr & ((1 << AW) - 1);
            col = (eff_addr >> AW) & ((1 << AW) - 1);
            if (paired_banks) en = (eff_bank >= 2) ? 12 : 3;
            else en = 1 << eff_bank;
            refr = (m_phase == 4) ? 1 : ext_ref_now();
            ras_act = (m_phase >= 1 && m_phase <= 3) ||
                      (ext_ctrl && m_phase == 0 && access_req);
            colsel = (m_phase == 2 || m_phase == 3) ||
                     (ext_ctrl && m_phase == 0 && access_req && mux_col_in);
            cas_act = (m_phase == 3) || (ext_ctrl && m_phase == 0 && access_req && cas_in);
            exp_ras = refr ? 0 : (ras_act ? (15 & ~en) : 15);
            exp_addr = refr ? m_refcnt : (colsel ? col : row);
            check_eq("ras_n", int'(ras_n), exp_ras);
            check_eq("cas_n", int'(cas_n), (cas_act && !refr) ? 0 : 1);
            check_eq("dram_addr", int'(dram_addr), exp_addr);
            check_eq("we_n R11", int'(we_n), int'(write_n));
            check_eq("access_done", int'(access_done), m_done);
        end
    end

    // model update at each rising edge
    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_pend = 0; m_refcnt = 0; m_done = 0; m_extq = 0;
            m_held_addr = 0; m_held_bank = 0;
        end else begin
            int exr, nphase, start_r, hold_last;
            exr = ext_ref_now();
            nphase = m_phase;
            start_r = 0;
            hold_last = long_row_hold ? 1 : 0;
            m_done = (m_phase == 2 && access_req) ? 1 : 0;
            if (m_extq && !exr) m_refcnt = (m_refcnt + 1) % (1 << RW);
            m_extq = exr;
            case (m_phase)
                0: if (!ext_ctrl) begin
                       if (m_pend || refresh_req) begin nphase = 4; m_cnt = 0; start_r = 1; end
                       else if (access_req) begin nphase = 1; m_cnt = 0; end
                   end
                1: if (!access_req) nphase = 0;
                   else if (m_cnt >= hold_last) nphase = 2;
                   else m_cnt++;
                2: nphase = access_req ? 3 : 0;
                3: if (!access_req) nphase = 0;
                default: if (m_cnt >= REF_CYC - 1) begin
                             nphase = 0;
                             m_refcnt = (m_refcnt + 1) % (1 << RW);
                         end else m_cnt++;
            endcase
            m_pend = (m_pend || (refresh_req && !ext_ctrl)) && !start_r;
            m_phase = nphase;
            if (addr_strobe) begin
                m_held_addr = int'(sys_addr);
                m_held_bank = int'(bank_sel);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic auto_access(int addr, int bank, int len);
        sys_addr = 20'(addr); bank_sel = 2'(bank); addr_strobe = 1'b1;
        cyc(1);
        addr_strobe = 1'b0; access_req = 1'b1;
        sys_addr = ~sys_addr;
        cyc(len);
        access_req = 1'b0;
        cyc(2);
        addr_strobe = 1'b1;
    endtask

    task automatic refresh_pulse();
        refresh_req = 1'b1;
        cyc(1);
        refresh_req = 1'b0;
        cyc(REF_CYC + 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        // R12: control idle after reset
        cur_req = "R12";
        cyc(2);
        check_eq("R12 ras_n after reset", int'(ras_n), 15);
        check_eq("R12 cas_n after reset", int'(cas_n), 1);
        refresh_req = 1'b1;
        cyc(1);
        refresh_req = 1'b0;
        cyc(1);
        check_eq("R12 first refresh address", int'(dram_addr), 0);
        cyc(REF_CYC);

        // R11: write enable follows input
        cur_req = "R11";
        for (int i = 0; i < 6; i++) begin
            write_n = i[0];
            cyc(1);
        end
        write_n = 1'b1;

        // R1: pass-through then hold
        cur_req = "R1";
        addr_strobe = 1'b1; sys_addr = 20'h5A3C1;
        cyc(1);
        check_eq("R1 pass-through row", int'(dram_addr), 20'h5A3C1 & 20'h3FF);
        addr_strobe = 1'b0; sys_addr = 20'h0F0F0;
        cyc(2);
        check_eq("R1 held row", int'(dram_addr), 20'h5A3C1 & 20'h3FF);
        sys_addr = 20'hFFFFF;
        cyc(1);
        addr_strobe = 1'b1;
        cyc(1);

        // R2, R4: four-bank automatic accesses with short hold
        cur_req = "R2";
        for (int b = 0; b < 4; b++) auto_access(20'h12345 + b * 20'h01111, b, 5);
        cur_req = "R4";
        auto_access(20'hABCDE, 1, 6);
        write_n = 1'b0;
        auto_access(20'h33333, 2, 4);
        write_n = 1'b1;

        // R5: long hold, then switch back
        cur_req = "R5";
        long_row_hold = 1'b1;
        auto_access(20'h2468A, 3, 6);
        long_row_hold = 1'b0;
        auto_access(20'h13579, 0, 6);

        // R3: paired decode
        cur_req = "R3";
        paired_banks = 1'b1;
        for (int b = 0; b < 4; b++) auto_access(20'h0C3A5 ^ (b * 20'h10101), b, 5);
        paired_banks = 1'b0;

        // R6, R7: done pulse and early release
        cur_req = "R6";
        auto_access(20'h77777, 2, 8);
        cur_req = "R7";
        auto_access(20'h11111, 1, 1);
        auto_access(20'h22222, 3, 2);
        auto_access(20'h44444, 0, 3);

        // R8: external access with several CAS pulses
        cur_req = "R8";
        ext_ctrl = 1'b1;
        sys_addr = 20'h9C8D7; bank_sel = 2'd2;
        cyc(1);
        access_req = 1'b1;
        cyc(1);
        mux_col_in = 1'b1;
        cyc(1);
        for (int k = 0; k < 3; k++) begin
            cas_in = 1'b1; cyc(1);
            cas_in = 1'b0; cyc(1);
        end
        access_req = 1'b0; mux_col_in = 1'b0;
        cyc(2);

        // R14: external refresh
        cur_req = "R14";
        for (int k = 0; k < 3; k++) begin
            refresh_req = 1'b1; cyc(2);
            refresh_req = 1'b0; cyc(1);
        end
        access_req = 1'b1; refresh_req = 1'b1;
        cyc(2);
        access_req = 1'b0;
        cyc(2);
        refresh_req = 1'b0;
        cyc(2);
        ext_ctrl = 1'b0;
        cyc(1);

        // R13: arbitration between refresh and access
        cur_req = "R13";
        sys_addr = 20'h5555A; bank_sel = 2'd1;
        access_req = 1'b1;
        cyc(2);
        refresh_req = 1'b1; cyc(1); refresh_req = 1'b0;
        cyc(4);
        access_req = 1'b0;
        cyc(REF_CYC + 3);
        refresh_req = 1'b1; cyc(1); refresh_req = 1'b0;
        access_req = 1'b1;
        cyc(REF_CYC + 5);
        access_req = 1'b0;
        cyc(2);
        refresh_req = 1'b1; access_req = 1'b1;
        cyc(1);
        refresh_req = 1'b0;
        cyc(REF_CYC + 5);
        access_req = 1'b0;
        cyc(2);

        // R9, R10: many refreshes, counter wraps
        cur_req = "R9";
        for (int k = 0; k < 4; k++) refresh_pulse();
        cur_req = "R10";
        for (int k = 0; k < 520; k++) refresh_pulse();
        refresh_req = 1'b1; cyc(1); refresh_req = 1'b0;
        cyc(1);
        check_eq("R10 address after wrap", int'(dram_addr), m_refcnt);
        cyc(REF_CYC + 2);

        finish_run();
    end
endmodule